// File: doc/BRIEF.md
# Host Port Initialization and DMA Packing Controller

This block controls a byte-wide parallel port through which an external host exchanges 24-bit words with a processor. It holds a host-writable control register that selects one of four transfer modes, enables host requests for each direction, and carries a command bit that asks the port to reinitialize itself. While that command is carried out, the block resets a chosen subset of the four handshake flags and presets a two-bit byte-lane counter.

In the three DMA modes the lane counter steps through the byte lanes of each word on every host acknowledge. The preset value decides how many bytes make a word: three, two or one. When the last lane has been transferred, the counter returns to its preset and the block reports a completed word to the processor side. In interrupt mode every acknowledged host access is one whole word and the counter stays at zero. The host request output tells the host when the port can move data in an enabled direction.

Top module: `hpi_init_pack`

## Requirements
- R1: After reset the control register reads 0x00, the lane counter is 0, both full flags are 0, both empty flags are 1, and host request, word-complete and init-error are 0.
- R2: A register write with bit 0 (init) set makes bit 0 read 1 in the cycle that follows. At the end of that cycle the initialization is carried out and bit 0 returns to 0 on its own.
- R3: The register reads back its fields as bit 0 init, bits 2:1 mode, bit 3 receive-request enable, bit 4 transmit-request enable, and bits 7:5 as zero. The mode encodings are 00 interrupt (no DMA), 01 DMA 24-bit, 10 DMA 16-bit and 11 DMA 8-bit.
- R4: Initialization loads the lane counter with the mode value, which gives 0 in interrupt mode.
- R5: Initialization with both enables clear leaves all four handshake flags unchanged.
- R6: Initialization with the receive enable set clears the host-to-processor full flag and sets the host-transmit empty flag.
- R7: Initialization with the transmit enable set sets the processor-transmit empty flag and clears the processor-to-host full flag. In interrupt mode, with both enables set, the updates of R6 and R7 both apply.
- R8: Initialization in a DMA mode with both enables set pulses init-error for one cycle after execution and changes no flag. The counter is still loaded and init still clears.
- R9: In a DMA mode each host acknowledge advances the lane counter by one. An acknowledge at lane 3 reloads the mode value and raises word-complete for exactly the next cycle.
- R10: Host request equals (transmit enable AND processor-to-host full) OR (receive enable AND host-transmit empty), taken from the present flag values.
- R11: In interrupt mode every host acknowledge is a whole-word transfer, and the lane counter stays at 0.
- R12: A whole-word host write sets host-to-processor full and clears host-transmit empty. A whole-word host read clears processor-to-host full and sets processor-transmit empty. A processor read of the received word clears host-to-processor full and sets host-transmit empty. A processor write of a word sets processor-to-host full and clears processor-transmit empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe for the control register |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Control register read value |
| host_ack | input | 1 | Host acknowledge: one byte access (DMA) or one word access (interrupt mode) |
| host_rd | input | 1 | Direction of the acknowledged access, 1 = host reads |
| dsp_rx_rd | input | 1 | Processor has read the received word |
| dsp_tx_wr | input | 1 | Processor has written a word for the host |
| host_req | output | 1 | Request to the host |
| word_done | output | 1 | One-cycle pulse after the last byte lane of a DMA word |
| init_err | output | 1 | One-cycle pulse after an illegal initialization |
| byte_lane | output | 2 | Current byte-lane counter |
| h2p_full | output | 1 | Host-to-processor word is waiting |
| h2p_empty | output | 1 | Host may write the next word |
| p2h_full | output | 1 | Processor-to-host word is waiting |
| p2h_empty | output | 1 | Processor may write the next word |

## Verification
Every result except host request is registered. A register write, an acknowledge or a processor event applied in one cycle therefore shows up at the outputs right after the next rising edge. An initialization takes two edges: the first makes bit 0 read 1, the second applies flags and counter, and init-error and word-complete appear after that second edge. The driver applies each stimulus at a falling edge and pushes the snapshot it expects after the following rising edge. The monitor compares that snapshot a quarter period after the edge, once per cycle, with no extra slack.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

  localparam int REG_W  = 8;
  localparam int LANE_W = 2;
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'((1 << LANE_W) - 1);

  // control register bit positions
  localparam int B_INIT = 0;
  localparam int B_MODE = 1;   // two bits: B_MODE+1 : B_MODE
  localparam int B_RXEN = 3;
  localparam int B_TXEN = 4;

  typedef enum logic [1:0] {
    MODE_IRQ   = 2'b00,
    MODE_DMA24 = 2'b01,
    MODE_DMA16 = 2'b10,
    MODE_DMA8  = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    logic       tx_en;
    logic       rx_en;
    xfer_mode_e mode;
    logic       init;
  } ctrl_t;

endpackage

// File: rtl/hpi_ctrl_reg.sv
module hpi_ctrl_reg
  import hpi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl_o,
  output logic             init_exec_o
);

  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_q.init) ctrl_d.init = 1'b0;
    if (wr_en) begin
      ctrl_d.init  = wr_data[B_INIT];
      ctrl_d.mode  = xfer_mode_e'(wr_data[B_MODE+1:B_MODE]);
      ctrl_d.rx_en = wr_data[B_RXEN];
      ctrl_d.tx_en = wr_data[B_TXEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o      = ctrl_q;
  assign init_exec_o = ctrl_q.init;

endmodule

// File: rtl/hpi_hs_flags.sv
module hpi_hs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic init_apply,
  input  logic rx_en,
  input  logic tx_en,
  input  logic host_word_wr,
  input  logic host_word_rd,
  input  logic dsp_rx_rd,
  input  logic dsp_tx_wr,
  output logic h2p_full,
  output logic h2p_empty,
  output logic p2h_full,
  output logic p2h_empty
);

  logic h2p_full_q, h2p_empty_q, p2h_full_q, p2h_empty_q;
  logic h2p_full_d, h2p_empty_d, p2h_full_d, p2h_empty_d;

  always_comb begin
    h2p_full_d  = h2p_full_q;
    h2p_empty_d = h2p_empty_q;
    p2h_full_d  = p2h_full_q;
    p2h_empty_d = p2h_empty_q;
    if (host_word_wr) begin h2p_full_d = 1'b1; h2p_empty_d = 1'b0; end
    if (dsp_rx_rd)    begin h2p_full_d = 1'b0; h2p_empty_d = 1'b1; end
    if (host_word_rd) begin p2h_full_d = 1'b0; p2h_empty_d = 1'b1; end
    if (dsp_tx_wr)    begin p2h_full_d = 1'b1; p2h_empty_d = 1'b0; end
    if (init_apply && rx_en) begin h2p_full_d = 1'b0; h2p_empty_d = 1'b1; end
    if (init_apply && tx_en) begin p2h_full_d = 1'b0; p2h_empty_d = 1'b1; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2p_full_q  <= 1'b0;
      h2p_empty_q <= 1'b1;
      p2h_full_q  <= 1'b0;
      p2h_empty_q <= 1'b1;
    end else begin
      h2p_full_q  <= h2p_full_d;
      h2p_empty_q <= h2p_empty_d;
      p2h_full_q  <= p2h_full_d;
      p2h_empty_q <= p2h_empty_d;
    end
  end

  assign h2p_full  = h2p_full_q;
  assign h2p_empty = h2p_empty_q;
  assign p2h_full  = p2h_full_q;
  assign p2h_empty = p2h_empty_q;

endmodule

// File: rtl/hpi_lane_cnt.sv
module hpi_lane_cnt
  import hpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_exec,
  input  xfer_mode_e        mode,
  input  logic              ack,
  output logic [LANE_W-1:0] lane,
  output logic              word_last,
  output logic              word_done
);

  logic [LANE_W-1:0] lane_q, lane_d;
  logic              done_q, done_d;
  logic              dma_step;

  assign dma_step  = ack && (mode != MODE_IRQ) && !init_exec;
  assign word_last = dma_step && (lane_q == LANE_LAST);

  always_comb begin
    lane_d = lane_q;
    done_d = 1'b0;
    if (init_exec) begin
      lane_d = LANE_W'(mode);
    end else if (dma_step) begin
      if (lane_q == LANE_LAST) begin
        lane_d = LANE_W'(mode);
        done_d = 1'b1;
      end else begin
        lane_d = LANE_W'(lane_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      done_q <= 1'b0;
    end else begin
      lane_q <= lane_d;
      done_q <= done_d;
    end
  end

  assign lane      = lane_q;
  assign word_done = done_q;

endmodule

// File: rtl/hpi_init_pack.sv
module hpi_init_pack
  import hpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       host_ack,
  input  logic       host_rd,
  input  logic       dsp_rx_rd,
  input  logic       dsp_tx_wr,
  output logic       host_req,
  output logic       word_done,
  output logic       init_err,
  output logic [1:0] byte_lane,
  output logic       h2p_full,
  output logic       h2p_empty,
  output logic       p2h_full,
  output logic       p2h_empty
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctrl_t ctrl;
  logic  init_exec, illegal, init_apply;
  logic  word_last, host_word, host_word_wr, host_word_rd;
  logic  err_q, err_d;

  hpi_ctrl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (reg_wr),
    .wr_data    (reg_wdata),
    .ctrl_o     (ctrl),
    .init_exec_o(init_exec)
  );

  assign illegal    = init_exec && (ctrl.mode != MODE_IRQ) && ctrl.rx_en && ctrl.tx_en;
  assign init_apply = init_exec && !illegal;

  hpi_lane_cnt u_lane (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .init_exec(init_exec),
    .mode     (ctrl.mode),
    .ack      (host_ack),
    .lane     (byte_lane),
    .word_last(word_last),
    .word_done(word_done)
  );

  assign host_word    = (host_ack && (ctrl.mode == MODE_IRQ)) || word_last;
  assign host_word_wr = host_word && !host_rd;
  assign host_word_rd = host_word && host_rd;

  hpi_hs_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .init_apply  (init_apply),
    .rx_en       (ctrl.rx_en),
    .tx_en       (ctrl.tx_en),
    .host_word_wr(host_word_wr),
    .host_word_rd(host_word_rd),
    .dsp_rx_rd   (dsp_rx_rd),
    .dsp_tx_wr   (dsp_tx_wr),
    .h2p_full    (h2p_full),
    .h2p_empty   (h2p_empty),
    .p2h_full    (p2h_full),
    .p2h_empty   (p2h_empty)
  );

  always_comb err_d = illegal;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else            err_q <= err_d;
  end
  assign init_err = err_q;

  assign host_req = (ctrl.tx_en && p2h_full) || (ctrl.rx_en && h2p_empty);

  always_comb begin
    reg_rdata                   = '0;
    reg_rdata[B_INIT]           = ctrl.init;
    reg_rdata[B_MODE+1:B_MODE]  = ctrl.mode;
    reg_rdata[B_RXEN]           = ctrl.rx_en;
    reg_rdata[B_TXEN]           = ctrl.tx_en;
  end

endmodule

// File: rtl/hpi_init_pack_chk.sv
module hpi_init_pack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       host_ack,
  input logic       dsp_rx_rd,
  input logic       dsp_tx_wr,
  input logic       host_req,
  input logic       word_done,
  input logic       init_err,
  input logic [1:0] byte_lane,
  input logic       h2p_full,
  input logic       h2p_empty,
  input logic       p2h_full,
  input logic       p2h_empty
);

  logic bad_init;
  assign bad_init = reg_rdata[0] && reg_rdata[3] && reg_rdata[4] && (reg_rdata[2:1] != 2'b00);

  a_r2_init_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] && !reg_wr |=> !reg_rdata[0]);

  a_r4_lane_preset: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] |=> byte_lane == $past(reg_rdata[2:1]));

  a_r6_rx_init: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] && reg_rdata[3] && !bad_init |=> !h2p_full && h2p_empty);

  a_r7_tx_init: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] && reg_rdata[4] && !bad_init |=> !p2h_full && p2h_empty);

  a_r8_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bad_init && !host_ack && !dsp_rx_rd && !dsp_tx_wr |=>
      init_err && $stable({h2p_full, h2p_empty, p2h_full, p2h_empty}));

  a_r9_done_reload: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(host_ack) && byte_lane == $past(reg_rdata[2:1]));

  a_r10_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[3] && !reg_rdata[4] |-> !host_req);

endmodule

bind hpi_init_pack hpi_init_pack_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rdata(reg_rdata),
  .host_ack (host_ack),
  .dsp_rx_rd(dsp_rx_rd),
  .dsp_tx_wr(dsp_tx_wr),
  .host_req (host_req),
  .word_done(word_done),
  .init_err (init_err),
  .byte_lane(byte_lane),
  .h2p_full (h2p_full),
  .h2p_empty(h2p_empty),
  .p2h_full (p2h_full),
  .p2h_empty(p2h_empty)
);

// File: tb/tb_hpi_init_pack.sv
module tb_hpi_init_pack;

  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       host_ack = 1'b0, host_rd = 1'b0, dsp_rx_rd = 1'b0, dsp_tx_wr = 1'b0;
  logic       host_req, word_done, init_err;
  logic [1:0] byte_lane;
  logic       h2p_full, h2p_empty, p2h_full, p2h_empty;

  always #(CLK_P/2) clk = ~clk;

  hpi_init_pack dut (.*);

  typedef struct {
    string      req;
    logic [16:0] exp;
  } item_t;

  item_t exp_q[$];
  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;

  // bench model state
  logic       m_init, m_rx, m_tx, m_h2pf, m_h2pe, m_p2hf, m_p2he, m_err, m_done;
  logic [1:0] m_mode, m_lane;

  function automatic logic [16:0] snap_exp();
    logic [7:0] rd;
    logic       req;
    rd  = {3'b000, m_tx, m_rx, m_mode, m_init};
    req = (m_tx && m_p2hf) || (m_rx && m_h2pe);
    return {rd, m_lane, m_h2pf, m_h2pe, m_p2hf, m_p2he, req, m_err, m_done};
  endfunction

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    while (exp_q.size() > 0) begin
      item_t it;
      logic [16:0] act;
      it  = exp_q.pop_front();
      act = {reg_rdata, byte_lane, h2p_full, h2p_empty, p2h_full, p2h_empty,
             host_req, init_err, word_done};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %05h expected %05h", it.req, act, it.exp);
      end
    end
  end

  // driver: one cycle of stimulus, model update, push expectation
  task automatic cyc(input string req, input logic we, input logic [7:0] wd,
                     input logic ack, input logic hrd, input logic drd, input logic dwr);
    logic exec, bad, hw;
    @(negedge clk);
    reg_wr = we; reg_wdata = wd; host_ack = ack; host_rd = hrd;
    dsp_rx_rd = drd; dsp_tx_wr = dwr;
    exec = m_init;
    bad  = exec && (m_mode != 2'b00) && m_rx && m_tx;
    hw   = ack && ((m_mode == 2'b00) || (m_lane == 2'b11 && !exec));
    // flags from data movement (R12)
    if (hw && !hrd) begin m_h2pf = 1; m_h2pe = 0; end
    if (drd)        begin m_h2pf = 0; m_h2pe = 1; end
    if (hw && hrd)  begin m_p2hf = 0; m_p2he = 1; end
    if (dwr)        begin m_p2hf = 1; m_p2he = 0; end
    // init updates (R5..R8)
    if (exec && !bad && m_rx) begin m_h2pf = 0; m_h2pe = 1; end
    if (exec && !bad && m_tx) begin m_p2hf = 0; m_p2he = 1; end
    m_err  = bad;
    m_done = 0;
    // lane counter (R4, R9, R11)
    if (exec) m_lane = m_mode;
    else if (ack && m_mode != 2'b00) begin
      if (m_lane == 2'b11) begin m_lane = m_mode; m_done = 1; end
      else m_lane = m_lane + 2'd1;
    end
    // register (R2, R3)
    if (exec) m_init = 0;
    if (we) begin
      m_init = wd[0]; m_mode = wd[2:1]; m_rx = wd[3]; m_tx = wd[4];
    end
    exp_q.push_back('{req, snap_exp()});
  endtask

  task automatic idle(input string req);
    cyc(req, 0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic wreg(input string req, input logic [7:0] v);
    cyc(req, 1, v, 0, 0, 0, 0);
  endtask

  task automatic ack(input string req, input logic hrd);
    cyc(req, 0, 8'h00, 1, hrd, 0, 0);
  endtask

  initial begin
    m_init = 0; m_mode = 0; m_rx = 0; m_tx = 0; m_lane = 0;
    m_h2pf = 0; m_h2pe = 1; m_p2hf = 0; m_p2he = 1; m_err = 0; m_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    idle("R1 reset state");

    // interrupt mode data movement
    cyc("R12 processor word write", 0, 8'h00, 0, 0, 0, 1);
    ack("R11/R12 irq host word write", 0);
    ack("R11 irq lane stays zero", 0);

    // readback and receive init
    wreg("R3 field readback", 8'h08);
    wreg("R2 init reads one", 8'h09);
    idle("R6 rx init and R10 request");
    idle("R2 init cleared");

    // transmit init
    cyc("R12 processor word write", 0, 8'h00, 0, 0, 0, 1);
    wreg("R2 tx init written", 8'h11);
    idle("R7 tx init");
    cyc("R10 request on tx data", 0, 8'h00, 0, 0, 0, 1);
    ack("R12/R10 host word read", 1);

    // init with neither enable
    cyc("R12 processor word write", 0, 8'h00, 0, 0, 0, 1);
    ack("R12 host word write", 0);
    wreg("R5 bare init", 8'h01);
    idle("R5 flags unchanged");

    // interrupt mode both enables
    wreg("R6/R7 both init", 8'h19);
    idle("R6/R7 both updates");

    // DMA 24-bit
    wreg("R3 dma24 select", 8'h0A);
    wreg("R4 dma24 init", 8'h0B);
    idle("R4 lane preset one");
    ack("R9 lane step", 0);
    ack("R9 lane step", 0);
    ack("R9 wrap and done", 0);
    idle("R9 done single pulse");
    cyc("R12 processor reads word", 0, 8'h00, 0, 0, 1, 0);

    // DMA 16-bit, host reading
    wreg("R4 dma16 init", 8'h15);
    idle("R4 lane preset two");
    cyc("R10 tx request", 0, 8'h00, 0, 0, 0, 1);
    ack("R9 lane step", 1);
    ack("R9/R12 wrap host read", 1);
    idle("R9 done cleared");

    // DMA 8-bit
    wreg("R4 dma8 init", 8'h07);
    idle("R4 lane preset three");
    ack("R9 single byte word", 0);
    ack("R9 second word", 0);
    cyc("R12 processor word write", 0, 8'h00, 0, 0, 0, 1);

    // illegal init
    wreg("R8 illegal init written", 8'h1F);
    idle("R8 error and flags held");
    idle("R8 error single pulse");
    idle("R10 request after illegal init");

    repeat (2) @(posedge clk);
    #(CLK_P/2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule